// File: doc/BRIEF.md
# Ring Router Node with Dateline Virtual Channels

This block is a single router node for a unidirectional ring whose last node links back to the first. That wrap-around makes paths shorter on average. It also creates a cycle of buffers: if every buffer in the cycle fills, each packet waits for space held by the next one, and the ring locks up. Each physical link carries two virtual channels, VC0 and VC1. Each channel has its own input buffer and its own credit counter.

Packets are single flits that carry a destination node index and a data word. A packet starts on VC0. One link is the dateline: the link leaving node `NODES-1` toward node 0. Every packet sent across that link is placed on VC1, and from then on it stays on VC1. No packet can go all the way around the ring on one channel, so the buffer dependency graph has no cycle.

At each node, a flit whose destination matches the node leaves through the local eject port. Any other flit is forwarded downstream. Local injection, forwarding from VC0 and forwarding from VC1 share the output link under round-robin arbitration.

Top module: `ring_vc_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rout_valid`, `ej_valid` and both `rin_credit` bits are 0. Each output credit counter starts at `DEPTH`.
- R2: A flit that reaches the head of an input VC buffer leaves through the eject port if its destination equals `NODE_ID`, with its data on `ej_data`. Otherwise it is forwarded on the ring output with its destination and data unchanged.
- R3: `rout_vc` uses 0 for VC0 and 1 for VC1. On node `NODES-1`, every flit sent carries `rout_vc`=1. On any other node, a forwarded flit keeps the VC it arrived on and an injected flit uses VC0. A flit from source node s seen on the output of node k is therefore on VC1 exactly when k=`NODES-1` or s>k.
- R4: A flit is sent on VC v only when the credit counter for v is nonzero. For each VC, the downstream node never holds more than `DEPTH` flits that have not been credited back. One `rin_credit[v]` pulse is returned for each flit popped from local buffer v.
- R5: The three requesters (VC0 forward, VC1 forward, inject) are served round-robin. When two or more are eligible in two consecutive cycles, the same requester is not granted in both. Under saturating traffic every node completes all of its injections.
- R6: At most one flit is ejected per cycle. When both VC heads are bound for this node in consecutive ejecting cycles, the ejections alternate between the two VCs. Every node receives every packet addressed to it.
- R7: On a ring of routers under saturating all-to-all traffic, every packet is delivered exactly once with no deadlock. Packets between one source and destination pair arrive in injection order.
- R8: `inj_ready` is high only in a cycle in which the offered flit is taken. The flit appears on `rout_*` after the next clock edge. A node never injects to its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Local flit offered |
| inj_dest | input | AW | Destination node of the offered flit |
| inj_data | input | DW | Data of the offered flit |
| inj_ready | output | 1 | Offered flit taken this cycle |
| ej_valid | output | 1 | Ejected flit valid |
| ej_data | output | DW | Ejected flit data |
| rin_valid | input | 1 | Flit arriving from upstream |
| rin_vc | input | 1 | VC of arriving flit |
| rin_dest | input | AW | Destination of arriving flit |
| rin_data | input | DW | Data of arriving flit |
| rin_credit | output | 2 | Credit return to upstream, one bit per VC |
| rout_valid | output | 1 | Flit sent downstream |
| rout_vc | output | 1 | VC of sent flit |
| rout_dest | output | AW | Destination of sent flit |
| rout_data | output | DW | Data of sent flit |
| rout_credit | input | 2 | Credit return from downstream, one bit per VC |

## Verification
The bench builds a four-node ring with two-entry buffers. Every node floods the ring with packets to every other node, which keeps all link buffers and credits at their limits.

Each flit on every link is checked for the right VC given its source and the link's position relative to the dateline. A router that forgot to switch at the dateline, or that switched back afterwards, would show a wrong VC. If it also let the cycle form, the ring would stall until the watchdog fires.

Credits are reconciled on every link. A router that sent without credit, or that leaked credits, would exceed the bound or fail to drain to zero at the end. Per-pair sequence numbers and per-node totals catch lost, duplicated, misrouted or reordered packets. Tracking when each injection is taken catches starvation and a wrong `inj_ready`.

// File: rtl/ring_vc_router.sv
module ring_vc_router #(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int DEPTH   = 2,
  parameter int DW      = 12,
  localparam int AW     = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_valid,
  input  logic [AW-1:0] inj_dest,
  input  logic [DW-1:0] inj_data,
  output logic          inj_ready,
  output logic          ej_valid,
  output logic [DW-1:0] ej_data,
  input  logic          rin_valid,
  input  logic          rin_vc,
  input  logic [AW-1:0] rin_dest,
  input  logic [DW-1:0] rin_data,
  output logic [1:0]    rin_credit,
  output logic          rout_valid,
  output logic          rout_vc,
  output logic [AW-1:0] rout_dest,
  output logic [DW-1:0] rout_data,
  input  logic [1:0]    rout_credit
);
  localparam int  FW  = AW + DW;
  localparam int  PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int  CW  = $clog2(DEPTH + 1);
  localparam bit  DL  = (NODE_ID == NODES - 1);
  localparam logic [AW-1:0] ME = AW'(NODE_ID);

  logic [FW-1:0] mem [2][DEPTH];
  logic [PW-1:0] wp [2];
  logic [PW-1:0] rp [2];
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] crd [2];
  logic [FW-1:0] hf [2];
  logic [1:0]    want_ej, want_fw, push, pop, ej_sel, fw_ovc;
  logic [2:0]    elig, gnt;
  logic [1:0]    last;
  logic          ej_pref, inj_ovc, send, ovc_sel, multi;
  logic [FW-1:0] sel_flit;

  for (genvar v = 0; v < 2; v++) begin : g_vc
    assign hf[v]      = mem[v][rp[v]];
    assign want_ej[v] = (cnt[v] != '0) && (hf[v][FW-1 -: AW] == ME);
    assign want_fw[v] = (cnt[v] != '0) && (hf[v][FW-1 -: AW] != ME);
    assign fw_ovc[v]  = DL ? 1'b1 : 1'(v);
    assign elig[v]    = want_fw[v] && (crd[fw_ovc[v]] != '0);
    assign push[v]    = rin_valid && (rin_vc == 1'(v));
    assign pop[v]     = gnt[v] | ej_sel[v];
  end

  assign inj_ovc = DL;
  assign elig[2] = inj_valid && (crd[inj_ovc] != '0);
  assign multi   = $countones(elig) > 1;

  always_comb begin
    gnt = '0;
    for (int i = 1; i <= 3; i++)
      if (gnt == '0 && elig[(int'(last) + i) % 3]) gnt[(int'(last) + i) % 3] = 1'b1;
  end

  always_comb begin
    ej_sel = '0;
    if (&want_ej) ej_sel[ej_pref] = 1'b1;
    else          ej_sel = want_ej;
  end

  assign send      = |gnt;
  assign inj_ready = gnt[2];
  assign ovc_sel   = gnt[2] ? inj_ovc : gnt[1] ? fw_ovc[1] : fw_ovc[0];
  assign sel_flit  = gnt[2] ? {inj_dest, inj_data} : gnt[1] ? hf[1] : hf[0];

  always_ff @(posedge clk)
    for (int v = 0; v < 2; v++)
      if (push[v]) mem[v][wp[v]] <= {rin_dest, rin_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        wp[v] <= '0; rp[v] <= '0; cnt[v] <= '0; crd[v] <= CW'(DEPTH);
      end
      last       <= '0;
      ej_pref    <= 1'b0;
      rout_valid <= 1'b0;
      rout_vc    <= 1'b0;
      rout_dest  <= '0;
      rout_data  <= '0;
      ej_valid   <= 1'b0;
      ej_data    <= '0;
      rin_credit <= '0;
    end else begin
      for (int v = 0; v < 2; v++) begin
        if (push[v]) wp[v] <= (wp[v] == PW'(DEPTH - 1)) ? '0 : wp[v] + 1'b1;
        if (pop[v])  rp[v] <= (rp[v] == PW'(DEPTH - 1)) ? '0 : rp[v] + 1'b1;
        cnt[v] <= cnt[v] + CW'(push[v]) - CW'(pop[v]);
        crd[v] <= crd[v] + CW'(rout_credit[v]) - CW'(send && (ovc_sel == 1'(v)));
      end
      if (send) last <= gnt[2] ? 2'd2 : gnt[1] ? 2'd1 : 2'd0;
      if (|ej_sel) ej_pref <= ej_sel[0];
      rout_valid <= send;
      rout_vc    <= ovc_sel;
      rout_dest  <= sel_flit[FW-1 -: AW];
      rout_data  <= sel_flit[DW-1:0];
      ej_valid   <= |ej_sel;
      ej_data    <= ej_sel[1] ? hf[1][DW-1:0] : hf[0][DW-1:0];
      rin_credit <= pop;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rin_valid |-> cnt[rin_vc] != CW'(DEPTH)); // R4
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    crd[0] <= CW'(DEPTH) && crd[1] <= CW'(DEPTH)); // R4
  AST_SEND_VC0_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rout_valid && !rout_vc) |-> $past(crd[0]) != '0); // R4
  AST_SEND_VC1_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rout_valid && rout_vc) |-> $past(crd[1]) != '0); // R4
  AST_DATELINE_VC1: assert property (@(posedge clk) disable iff (!rst_n)
    (DL && rout_valid) |-> rout_vc); // R3
  AST_INJ_ON_VC0: assert property (@(posedge clk) disable iff (!rst_n)
    (!DL && inj_ready) |=> (rout_valid && !rout_vc)); // R3
  AST_RR_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && $past(multi)) |-> gnt != $past(gnt)); // R5
  AST_EJ_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (&want_ej && $past(&want_ej)) |-> ej_sel != $past(ej_sel)); // R6
  AST_NO_SELF_INJ: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> inj_dest != ME); // R8
endmodule

// File: tb/ring_vc_router_tb_top.sv
module ring_vc_router_tb_top;
  localparam int N = 4, DEPTH = 2, DW = 12, AW = 2, ROUNDS = 8;
  localparam int PER_NODE = ROUNDS * (N - 1), TOTAL = N * PER_NODE, LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] inj_valid, inj_ready, ej_valid, rout_valid, rout_vc;
  logic [AW-1:0] inj_dest [N];
  logic [AW-1:0] rout_dest [N];
  logic [DW-1:0] inj_data [N];
  logic [DW-1:0] ej_data [N];
  logic [DW-1:0] rout_data [N];
  logic [1:0]    rin_credit [N];

  for (genvar g = 0; g < N; g++) begin : g_node
    localparam int PV = (g + N - 1) % N;
    localparam int NX = (g + 1) % N;
    ring_vc_router #(.NODES(N), .NODE_ID(g), .DEPTH(DEPTH), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .inj_valid(inj_valid[g]), .inj_dest(inj_dest[g]), .inj_data(inj_data[g]),
      .inj_ready(inj_ready[g]),
      .ej_valid(ej_valid[g]), .ej_data(ej_data[g]),
      .rin_valid(rout_valid[PV]), .rin_vc(rout_vc[PV]), .rin_dest(rout_dest[PV]),
      .rin_data(rout_data[PV]), .rin_credit(rin_credit[g]),
      .rout_valid(rout_valid[g]), .rout_vc(rout_vc[g]), .rout_dest(rout_dest[g]),
      .rout_data(rout_data[g]), .rout_credit(rin_credit[NX])
    );
  end

  int total = 0, bad = 0;
  int ptr [N];
  int got [N];
  int nseq [N][N];
  int outst [N][2];
  bit pfire [N];
  logic [DW-1:0] pdata [N];
  logic [AW-1:0] pdest [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pkt(input int s, input int p);
    int d;
    d = (s + 1 + (p % (N - 1))) % N;
    return {AW'(s), AW'(d), 8'(p / (N - 1))};
  endfunction

  initial begin
    int cyc, drain;
    for (int k = 0; k < N; k++) begin
      ptr[k] = 0; got[k] = 0; pfire[k] = 0;
      inj_valid[k] = 0; inj_dest[k] = '0; inj_data[k] = '0;
      for (int j = 0; j < N; j++) nseq[k][j] = 0;
      outst[k][0] = 0; outst[k][1] = 0;
    end
    repeat (3) @(negedge clk);
    #8;
    for (int k = 0; k < N; k++) begin
      chk(rout_valid[k] == 0 && ej_valid[k] == 0, "R1 idle outputs in reset", int'(rout_valid[k]), 0);
      chk(rin_credit[k] == 2'b00, "R1 no credit in reset", int'(rin_credit[k]), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    #8;
    for (int k = 0; k < N; k++)
      chk(rout_valid[k] == 0 && ej_valid[k] == 0 && rin_credit[k] == 2'b00,
          "R1 idle after reset", int'(rout_valid[k]), 0);
    cyc = 0; drain = 0;
    while (drain < 12 && cyc < LIMIT) begin
      @(negedge clk); cyc++;
      for (int k = 0; k < N; k++) begin
        inj_valid[k] = ptr[k] < PER_NODE;
        inj_data[k]  = pkt(k, ptr[k]);
        inj_dest[k]  = inj_data[k][DW-AW-1 -: AW];
      end
      #8;
      for (int k = 0; k < N; k++) begin
        if (ej_valid[k]) begin
          int s, d, q;
          s = int'(ej_data[k][DW-1 -: AW]);
          d = int'(ej_data[k][DW-AW-1 -: AW]);
          q = int'(ej_data[k][7:0]);
          chk(d == k, "R2 eject at destination", d, k);
          chk(q == nseq[s][k], "R7 pair order", q, nseq[s][k]);
          nseq[s][k] = q + 1;
          got[k]++;
        end
        if (rout_valid[k]) begin
          int s;
          bit ev;
          s = int'(rout_data[k][DW-1 -: AW]);
          ev = (k == N - 1) || (s > k);
          chk(rout_vc[k] == ev, "R3 dateline vc", int'(rout_vc[k]), int'(ev));
          chk(int'(rout_dest[k]) != (k + 1) % N || rout_dest[k] == rout_data[k][DW-AW-1 -: AW],
              "R2 forwarded dest intact", int'(rout_dest[k]), int'(rout_data[k][DW-AW-1 -: AW]));
          outst[k][rout_vc[k]]++;
        end
        if (pfire[k])
          chk(rout_valid[k] && rout_data[k] == pdata[k] && rout_dest[k] == pdest[k],
              "R8 injected flit on output", int'(rout_data[k]), int'(pdata[k]));
      end
      for (int k = 0; k < N; k++)
        for (int v = 0; v < 2; v++) begin
          if (rin_credit[(k + 1) % N][v]) outst[k][v]--;
          chk(outst[k][v] >= 0 && outst[k][v] <= DEPTH, "R4 credit window", outst[k][v], DEPTH);
        end
      for (int k = 0; k < N; k++) begin
        pfire[k] = inj_valid[k] && inj_ready[k];
        if (inj_ready[k] && !inj_valid[k]) chk(0, "R8 ready without valid", 1, 0);
        pdata[k] = inj_data[k];
        pdest[k] = inj_dest[k];
        if (pfire[k]) ptr[k]++;
      end
      if (got[0] + got[1] + got[2] + got[3] == TOTAL) drain++;
    end
    chk(cyc < LIMIT, "R7 no deadlock before watchdog", cyc, LIMIT);
    for (int k = 0; k < N; k++) begin
      chk(ptr[k] == PER_NODE, "R5 injections complete", ptr[k], PER_NODE);
      chk(got[k] == PER_NODE, "R6 ejections per node", got[k], PER_NODE);
      chk(outst[k][0] == 0 && outst[k][1] == 0, "R4 credits returned",
          outst[k][0] + outst[k][1], 0);
      for (int s = 0; s < N; s++)
        if (s != k) chk(nseq[s][k] == ROUNDS, "R7 all pair packets", nseq[s][k], ROUNDS);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule